// File: doc/BRIEF.md
# Transaction-Aware Persistent Victim Cache

This block sits in a memory controller in front of byte-addressable non-volatile memory. Software groups persistent stores into transactions that are recorded in a redo log. The last-level cache may have to evict a dirty line that belongs to a transaction which has not yet been copied to its home location. Such a line is parked here. A later last-level miss to the same line is served from this block, so the controller never has to search the log.

Each entry holds a line address, the line data and a copy of the in-flight transaction vector, one bit per core. The copy is taken when the line is captured. The controller broadcasts each retirement, meaning that a transaction's log has been fully copied home. The matching bit is then cleared in every entry at once. An entry whose copy has no bits left is released. Each entry also carries a "covered" flag, which is set when a log copy to the entry's own address passes by. A released entry that was never covered holds a store that exists nowhere else, such as a non-transactional store. That entry is first written to its home address through a valid/ready request port. A covered entry is dropped silently.

Top module: `txn_victim_cache`

## Requirements
- R1: An eviction is captured only when it is valid, dirty, and its address lies within [NVM_LO, NVM_HI] inclusive. Any other eviction creates no entry and is never stalled: evict_ready_o is 1 and overflow_o is 0.
- R2: A valid lookup that matches a held line raises lookup_hit_o in the same cycle and returns that line's data. A lookup that matches no line reports a miss.
- R3: A capturable eviction to a new line when all entries are in use raises overflow_o and drops evict_ready_o in the same cycle. The line is not stored.
- R4: A newly captured line records active_txn_i with the bit of any same-cycle retirement removed. A retirement of ID n (bit n) clears bit n in every entry. An entry whose record becomes all-zero is released at that edge.
- R5: A migrate notice (migrate_valid_i) whose address equals a held line sets that line's covered flag. A released covered line is dropped, with no home write, and misses on lookup from the next cycle.
- R6: A released line that is not covered raises wb_valid_o with its address and data. It stays visible to lookups until wb_valid_o and wb_ready_i are both high, and it misses in the cycle after that. While it waits, a capturable eviction to that line is stalled.
- R7: A line captured with an all-zero record is released at once, and wb_valid_o for it rises in the next cycle.
- R8: A capturable eviction to a line already held replaces the data, ORs the new record into the old one, and clears the covered flag. This includes an eviction that arrives in the same cycle as a migrate notice for that line.
- R9: When a retirement empties a line's record in the same cycle that a migrate notice covers that line, the line is dropped without a home write.
- R10: While wb_valid_o is high and wb_ready_i is low, the next cycle keeps wb_valid_o high with the same wb_addr_o and wb_data_o.
- R11: In reset the cache is empty: no hits, wb_valid_o low, evict_ready_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evict_valid_i | input | 1 | Eviction from last-level cache |
| evict_dirty_i | input | 1 | Evicted line is dirty |
| evict_addr_i | input | ADDR_W | Evicted line address |
| evict_data_i | input | DATA_W | Evicted line data |
| evict_ready_o | output | 1 | Eviction accepted this cycle |
| overflow_o | output | 1 | Capturable eviction stalled, no free entry |
| active_txn_i | input | NUM_CORES | In-flight transaction vector |
| retire_valid_i | input | 1 | Retirement broadcast |
| retire_id_i | input | ID_W | Retired transaction ID (bit index) |
| migrate_valid_i | input | 1 | Log entry copied home |
| migrate_addr_i | input | ADDR_W | Home address of that log entry |
| lookup_valid_i | input | 1 | Last-level miss lookup |
| lookup_addr_i | input | ADDR_W | Lookup line address |
| lookup_hit_o | output | 1 | Lookup hit |
| lookup_data_o | output | DATA_W | Hit data (zero on miss) |
| wb_valid_o | output | 1 | Home write request |
| wb_ready_i | input | 1 | Home write accepted |
| wb_addr_o | output | ADDR_W | Home write address |
| wb_data_o | output | DATA_W | Home write data |

## Verification
The riskiest overlap is a retirement that empties a line's record in the same edge where a migrate notice for that line arrives. The drop-or-write decision must then use the freshly set covered flag. A second overlap is an eviction that hits a line waiting on the home port. The bench forces both directly. It then drives thousands of random cycles in which evictions, retirements, migrate notices, lookups and a throttled wb_ready_i land on a small shared address pool, so these collisions recur often. Each cycle is judged against a bench-side line model built from the requirements. That model predicts hits, data, stalls, overflow and which lines must be offered for home write.

// File: rtl/tvc_pkg.sv
package tvc_pkg;
  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_HELD = 2'd1,
    ENT_HOME = 2'd2
  } ent_state_e;
endpackage

// File: rtl/tvc_pick_first.sv
module tvc_pick_first #(
  parameter int N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_pick
    assign gnt_o[g]     = req_i[g] && !taken[g];
    assign taken[g + 1] = taken[g] || req_i[g];
  end
endmodule

// File: rtl/tvc_entry.sv
module tvc_entry
  import tvc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int NC     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NC-1:0]     snap_i,
  input  logic [NC-1:0]     clr_i,
  input  logic              mig_valid_i,
  input  logic [ADDR_W-1:0] mig_addr_i,
  input  logic              grant_i,
  output ent_state_e        state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  ent_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [NC-1:0]     snap_q, snap_clr, snap_load;
  logic              cov_q, cov_n;

  assign snap_clr  = snap_q & ~clr_i;
  assign snap_load = ((state_q != ENT_FREE) ? snap_clr : '0) | snap_i;
  assign cov_n     = cov_q || (mig_valid_i && state_q == ENT_HELD && addr_q == mig_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENT_FREE;
      addr_q  <= '0;
      data_q  <= '0;
      snap_q  <= '0;
      cov_q   <= 1'b0;
    end else if (load_i) begin
      // new or merged capture: coverage restarts, empty record goes home
      addr_q  <= addr_i;
      data_q  <= data_i;
      snap_q  <= snap_load;
      cov_q   <= 1'b0;
      state_q <= (|snap_load) ? ENT_HELD : ENT_HOME;
    end else begin
      unique case (state_q)
        ENT_HELD: begin
          snap_q <= snap_clr;
          cov_q  <= cov_n;
          if (snap_clr == '0) state_q <= cov_n ? ENT_FREE : ENT_HOME;
        end
        ENT_HOME: if (grant_i) begin
          state_q <= ENT_FREE;
          cov_q   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign state_o = state_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/txn_victim_cache.sv
module txn_victim_cache
  import tvc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_CORES   = 4,
  parameter logic [ADDR_W-1:0] NVM_LO = 'h1000,
  parameter logic [ADDR_W-1:0] NVM_HI = 'h1FFF,
  localparam int ID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evict_valid_i,
  input  logic                 evict_dirty_i,
  input  logic [ADDR_W-1:0]    evict_addr_i,
  input  logic [DATA_W-1:0]    evict_data_i,
  output logic                 evict_ready_o,
  output logic                 overflow_o,
  input  logic [NUM_CORES-1:0] active_txn_i,
  input  logic                 retire_valid_i,
  input  logic [ID_W-1:0]      retire_id_i,
  input  logic                 migrate_valid_i,
  input  logic [ADDR_W-1:0]    migrate_addr_i,
  input  logic                 lookup_valid_i,
  input  logic [ADDR_W-1:0]    lookup_addr_i,
  output logic                 lookup_hit_o,
  output logic [DATA_W-1:0]    lookup_data_o,
  output logic                 wb_valid_o,
  input  logic                 wb_ready_i,
  output logic [ADDR_W-1:0]    wb_addr_o,
  output logic [DATA_W-1:0]    wb_data_o
);
  localparam int NE = NUM_ENTRIES;

  ent_state_e        ent_state [NE];
  logic [ADDR_W-1:0] ent_addr  [NE];
  logic [DATA_W-1:0] ent_data  [NE];

  logic [NE-1:0] is_free, is_home, ev_hit, lk_hit, load, grant;
  logic [NE-1:0] alloc_oh, home_first, wb_sel, lock_q;
  logic [NUM_CORES-1:0] clr_mask, snap_new;
  logic in_nvm, capt_req, any_ev_hit, home_hit, accept;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_clr
    assign clr_mask[c] = retire_valid_i && (retire_id_i == ID_W'(c));
  end
  assign snap_new = active_txn_i & ~clr_mask;

  assign in_nvm     = (evict_addr_i >= NVM_LO) && (evict_addr_i <= NVM_HI);
  assign capt_req   = evict_valid_i && evict_dirty_i && in_nvm;
  assign any_ev_hit = |ev_hit;
  assign home_hit   = |(ev_hit & is_home);
  assign overflow_o = capt_req && !any_ev_hit && !(|is_free);
  // a line awaiting its home write is frozen until the write is taken
  assign evict_ready_o = !(overflow_o || (capt_req && home_hit));
  assign accept        = capt_req && evict_ready_o;

  tvc_pick_first #(.N(NE)) u_pick_free (.req_i(is_free), .gnt_o(alloc_oh));
  tvc_pick_first #(.N(NE)) u_pick_home (.req_i(is_home), .gnt_o(home_first));

  assign wb_sel     = (|lock_q) ? lock_q : home_first;
  assign wb_valid_o = |is_home;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= '0;
    else         lock_q <= (wb_valid_o && !wb_ready_i) ? wb_sel : '0;
  end

  for (genvar g = 0; g < NE; g++) begin : g_ent
    assign is_free[g] = (ent_state[g] == ENT_FREE);
    assign is_home[g] = (ent_state[g] == ENT_HOME);
    assign ev_hit[g]  = !is_free[g] && (ent_addr[g] == evict_addr_i);
    assign lk_hit[g]  = lookup_valid_i && !is_free[g] && (ent_addr[g] == lookup_addr_i);
    assign load[g]    = accept && (ev_hit[g] || (!any_ev_hit && alloc_oh[g]));
    assign grant[g]   = wb_sel[g] && wb_ready_i;

    tvc_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NC(NUM_CORES)) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load[g]),
      .addr_i     (evict_addr_i),
      .data_i     (evict_data_i),
      .snap_i     (snap_new),
      .clr_i      (clr_mask),
      .mig_valid_i(migrate_valid_i),
      .mig_addr_i (migrate_addr_i),
      .grant_i    (grant[g]),
      .state_o    (ent_state[g]),
      .addr_o     (ent_addr[g]),
      .data_o     (ent_data[g])
    );
  end

  always_comb begin
    lookup_data_o = '0;
    wb_addr_o     = '0;
    wb_data_o     = '0;
    for (int i = 0; i < NE; i++) begin
      if (lk_hit[i]) lookup_data_o |= ent_data[i];
      if (wb_sel[i]) begin
        wb_addr_o |= ent_addr[i];
        wb_data_o |= ent_data[i];
      end
    end
  end
  assign lookup_hit_o = |lk_hit;
endmodule

// File: rtl/tvc_checker.sv
module tvc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter logic [ADDR_W-1:0] NVM_LO = 'h1000,
  parameter logic [ADDR_W-1:0] NVM_HI = 'h1FFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evict_valid_i,
  input logic              evict_dirty_i,
  input logic [ADDR_W-1:0] evict_addr_i,
  input logic              evict_ready_o,
  input logic              overflow_o,
  input logic              lookup_valid_i,
  input logic [ADDR_W-1:0] lookup_addr_i,
  input logic              lookup_hit_o,
  input logic [DATA_W-1:0] lookup_data_o,
  input logic              wb_valid_o,
  input logic              wb_ready_i,
  input logic [ADDR_W-1:0] wb_addr_o,
  input logic [DATA_W-1:0] wb_data_o
);
  logic in_nvm;
  assign in_nvm = (evict_addr_i >= NVM_LO) && (evict_addr_i <= NVM_HI);

  assert_bypass_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i && !(evict_dirty_i && in_nvm) |-> evict_ready_o && !overflow_o);

  assert_idle_miss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |-> !lookup_hit_o);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> !evict_ready_o && evict_valid_i && evict_dirty_i);

  assert_home_visible_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && lookup_valid_i && lookup_addr_i == wb_addr_o
      |-> lookup_hit_o && lookup_data_o == wb_data_o);

  assert_home_evict_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && evict_valid_i && evict_dirty_i && evict_addr_i == wb_addr_o
      |-> !evict_ready_o);

  assert_wb_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && !wb_ready_i
      |=> wb_valid_o && $stable(wb_addr_o) && $stable(wb_data_o));
endmodule

bind txn_victim_cache tvc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NVM_LO(NVM_LO), .NVM_HI(NVM_HI)
) u_tvc_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .evict_valid_i (evict_valid_i),
  .evict_dirty_i (evict_dirty_i),
  .evict_addr_i  (evict_addr_i),
  .evict_ready_o (evict_ready_o),
  .overflow_o    (overflow_o),
  .lookup_valid_i(lookup_valid_i),
  .lookup_addr_i (lookup_addr_i),
  .lookup_hit_o  (lookup_hit_o),
  .lookup_data_o (lookup_data_o),
  .wb_valid_o    (wb_valid_o),
  .wb_ready_i    (wb_ready_i),
  .wb_addr_o     (wb_addr_o),
  .wb_data_o     (wb_data_o)
);

// File: tb/txn_victim_cache_bench.sv
`timescale 1ns/1ps
module txn_victim_cache_bench;
  localparam int NE = 8;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ev_v = 0, ev_d = 0, ret_v = 0, mig_v = 0, lk_v = 0, wb_rdy = 0;
  logic [31:0] ev_a = 0, mig_a = 0, lk_a = 0;
  logic [63:0] ev_dat = 0;
  logic [3:0]  act = 0;
  logic [1:0]  ret_id = 0;
  logic        evict_ready_o, overflow_o, lookup_hit_o, wb_valid_o;
  logic [63:0] lookup_data_o, wb_data_o;
  logic [31:0] wb_addr_o;

  int n_chk = 0, n_fail = 0;

  // bench line model: state 0 free, 1 held, 2 awaiting home write
  int          mst [NE];
  logic [31:0] ma  [NE];
  logic [63:0] md  [NE];
  logic [3:0]  ms  [NE];
  bit          mc  [NE];
  bit          p_stall = 0;
  logic [31:0] p_a;
  logic [63:0] p_d;

  always #4 clk_i = ~clk_i;

  txn_victim_cache u_txn_victim_cache (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .evict_valid_i(ev_v), .evict_dirty_i(ev_d), .evict_addr_i(ev_a), .evict_data_i(ev_dat),
    .evict_ready_o(evict_ready_o), .overflow_o(overflow_o),
    .active_txn_i(act), .retire_valid_i(ret_v), .retire_id_i(ret_id),
    .migrate_valid_i(mig_v), .migrate_addr_i(mig_a),
    .lookup_valid_i(lk_v), .lookup_addr_i(lk_a),
    .lookup_hit_o(lookup_hit_o), .lookup_data_o(lookup_data_o),
    .wb_valid_o(wb_valid_o), .wb_ready_i(wb_rdy),
    .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act_v, input logic [63:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act_v, exp_v);
    end
  endtask

  function automatic bit nvm(input logic [31:0] a);
    return a >= 32'h1000 && a <= 32'h1FFF;
  endfunction

  function automatic int mfind(input logic [31:0] a);
    for (int i = 0; i < NE; i++) if (mst[i] != 0 && ma[i] == a) return i;
    return -1;
  endfunction

  // check outputs against model, advance model, move to next negedge
  task automatic step();
    int h, l, nfree, idx, w;
    bit acc, hh, full, eh, anyh, fire, cn;
    logic [3:0] clr, sn;
    #1;
    if (p_stall) chk(wb_valid_o && wb_addr_o == p_a && wb_data_o == p_d, "R10", wb_addr_o, p_a);
    acc = ev_v && ev_d && nvm(ev_a);
    h = mfind(ev_a);
    hh = acc && h >= 0 && mst[h] == 2;
    nfree = 0;
    for (int i = 0; i < NE; i++) if (mst[i] == 0) nfree++;
    full = acc && h < 0 && nfree == 0;
    chk(evict_ready_o == !(full || hh), "R3 ready", evict_ready_o, !(full || hh));
    chk(overflow_o == full, "R3 overflow", overflow_o, full);
    l = mfind(lk_a);
    eh = lk_v && l >= 0;
    chk(lookup_hit_o == eh, "R2 hit", lookup_hit_o, eh);
    if (eh) chk(lookup_data_o == md[l], "R2 data", lookup_data_o, md[l]);
    anyh = 0;
    for (int i = 0; i < NE; i++) if (mst[i] == 2) anyh = 1;
    chk(wb_valid_o == anyh, "R6 wb_valid", wb_valid_o, anyh);
    if (wb_valid_o) begin
      w = mfind(wb_addr_o);
      chk(w >= 0 && mst[w] == 2 && md[w] == wb_data_o, "R6 wb line", wb_data_o, (w >= 0) ? md[w] : 64'hx);
    end
    fire = wb_valid_o && wb_rdy;
    p_stall = wb_valid_o && !wb_rdy;
    p_a = wb_addr_o;
    p_d = wb_data_o;
    clr = ret_v ? (4'b0001 << ret_id) : 4'b0000;
    idx = -1;
    if (acc && !hh && !full) begin
      if (h >= 0) idx = h;
      else for (int i = NE - 1; i >= 0; i--) if (mst[i] == 0) idx = i;
    end
    for (int i = 0; i < NE; i++) begin
      if (i == idx) begin
        sn = ((mst[i] != 0) ? (ms[i] & ~clr) : 4'b0) | (act & ~clr);
        ma[i] = ev_a; md[i] = ev_dat; ms[i] = sn; mc[i] = 0;
        mst[i] = (sn != 0) ? 1 : 2;
      end else if (mst[i] == 1) begin
        ms[i] = ms[i] & ~clr;
        cn = mc[i] || (mig_v && mig_a == ma[i]);
        mc[i] = cn;
        if (ms[i] == 0) mst[i] = cn ? 0 : 2;
      end else if (mst[i] == 2) begin
        if (fire && ma[i] == wb_addr_o) mst[i] = 0;
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    ev_v = 0; ret_v = 0; mig_v = 0; lk_v = 0;
  endtask

  task automatic ev(input logic [31:0] a, input logic [63:0] d, input bit dirty);
    ev_v = 1; ev_d = dirty; ev_a = a; ev_dat = d;
  endtask

  task automatic look(input logic [31:0] a);
    lk_v = 1; lk_a = a; #1;
  endtask

  task automatic retire(input logic [1:0] id);
    ret_v = 1; ret_id = id;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NE; i++) begin mst[i] = 0; ma[i] = 0; md[i] = 0; ms[i] = 0; mc[i] = 0; end
    repeat (3) @(negedge clk_i);
    look(32'h1000);
    chk(!wb_valid_o && evict_ready_o && !lookup_hit_o, "R11 reset", {wb_valid_o, evict_ready_o, lookup_hit_o}, 3'b010);
    lk_v = 0;
    rst_ni = 1;
    @(negedge clk_i);

    // R4 / R6 / R10: record of two txns, release on second retire, held home write
    act = 4'b0011; ev(32'h1000, 64'hA1, 1); step();
    look(32'h1000); chk(lookup_hit_o && lookup_data_o == 64'hA1, "R4 captured", lookup_data_o, 64'hA1); step();
    retire(0); step();
    look(32'h1000); chk(lookup_hit_o, "R4 partial retire keeps line", lookup_hit_o, 1); step();
    retire(1); step();
    #1; chk(wb_valid_o && wb_addr_o == 32'h1000 && wb_data_o == 64'hA1, "R6 home write", wb_addr_o, 32'h1000);
    step();
    ev(32'h1000, 64'hB9, 1); #1; chk(!evict_ready_o, "R6 evict stall on home line", evict_ready_o, 0); step();
    wb_rdy = 1; step(); wb_rdy = 0;
    look(32'h1000); chk(!lookup_hit_o, "R6 freed after handshake", lookup_hit_o, 0); step();

    // R5: covered line dropped silently
    act = 4'b0100; ev(32'h1001, 64'hC2, 1); step();
    mig_v = 1; mig_a = 32'h1001; step();
    retire(2); step();
    look(32'h1001); chk(!wb_valid_o && !lookup_hit_o, "R5 covered drop", {wb_valid_o, lookup_hit_o}, 0); step();

    // R9: retire and migrate in the same cycle
    act = 4'b1000; ev(32'h1002, 64'hD3, 1); step();
    retire(3); mig_v = 1; mig_a = 32'h1002; step();
    look(32'h1002); chk(!wb_valid_o && !lookup_hit_o, "R9 same-cycle drop", {wb_valid_o, lookup_hit_o}, 0); step();

    // R7: empty record at capture
    act = 4'b0000; ev(32'h1003, 64'hE4, 1); step();
    #1; chk(wb_valid_o && wb_addr_o == 32'h1003 && wb_data_o == 64'hE4, "R7 immediate home", wb_addr_o, 32'h1003);
    wb_rdy = 1; step(); wb_rdy = 0;

    // R8: merge on re-eviction
    act = 4'b0001; ev(32'h1004, 64'hF1, 1); step();
    act = 4'b0010; ev(32'h1004, 64'hF2, 1); mig_v = 1; mig_a = 32'h1004; step();
    look(32'h1004); chk(lookup_hit_o && lookup_data_o == 64'hF2, "R8 data replaced", lookup_data_o, 64'hF2); step();
    retire(0); step();
    look(32'h1004); chk(lookup_hit_o, "R8 record merged", lookup_hit_o, 1); step();
    retire(1); step();
    #1; chk(wb_valid_o && wb_addr_o == 32'h1004 && wb_data_o == 64'hF2, "R8 covered flag cleared", wb_data_o, 64'hF2);
    wb_rdy = 1; step(); wb_rdy = 0;

    // R3: fill then overflow
    act = 4'b0001;
    for (int k = 0; k < NE; k++) begin ev(32'h1010 + k, 64'h100 + k, 1); step(); end
    ev(32'h1020, 64'h77, 1); #1;
    chk(overflow_o && !evict_ready_o, "R3 full", {overflow_o, evict_ready_o}, 2'b10); step();
    look(32'h1020); chk(!lookup_hit_o, "R3 not stored", lookup_hit_o, 0); step();
    retire(0); step();
    wb_rdy = 1; repeat (NE) step(); wb_rdy = 0;
    #1; chk(!wb_valid_o, "R6 drained", wb_valid_o, 0);

    // R1: clean and out-of-range evictions bypass
    act = 4'b0001; ev(32'h1030, 64'h55, 0); step();
    look(32'h1030); chk(!lookup_hit_o, "R1 clean ignored", lookup_hit_o, 0); step();
    ev(32'h0050, 64'h66, 1); #1; chk(evict_ready_o && !overflow_o, "R1 bypass ready", evict_ready_o, 1); step();
    look(32'h0050); chk(!lookup_hit_o, "R1 out-of-range ignored", lookup_hit_o, 0); step();

    // random mix over a small shared pool
    for (int c = 0; c < 4000; c++) begin
      ev_v = ($urandom % 2) == 0;
      ev_d = ($urandom % 4) != 0;
      ev_a = (($urandom % 5) == 0) ? 32'h0040 + ($urandom % 8) : 32'h1000 + ($urandom % 12);
      ev_dat = {$urandom, $urandom};
      act = (($urandom % 8) == 0) ? 4'b0 : 4'($urandom);
      ret_v = ($urandom % 3) == 0;
      ret_id = 2'($urandom);
      mig_v = ($urandom % 4) == 0;
      mig_a = 32'h1000 + ($urandom % 12);
      wb_rdy = ($urandom % 3) != 0;
      lk_v = ($urandom % 8) != 0;
      lk_a = 32'h1000 + ($urandom % 12);
      step();
    end

    act = 4'b0; wb_rdy = 1;
    for (int k = 0; k < 4; k++) begin retire(2'(k)); step(); end
    repeat (NE + 2) step();
    #1; chk(!wb_valid_o, "R4 all retired and drained", wb_valid_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule